// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block looks after a circular table of receive buffer descriptors kept in system memory. The host programs four 16-bit pointers: where the ring starts, where it ends, where the block will read the next descriptor and how far the host has refilled the ring. On request the block reads one descriptor through a simple request/response memory port and loads the current buffer address and the remaining word count from it. After that it charges each received packet against the remaining space.

A descriptor holds four 16-bit words, read in this order: buffer address bits 15:0, buffer address bits 31:16, word count bits 15:0, word count bits 31:16. In narrow (16-bit) mode the words sit 2 bytes apart, so one descriptor spans 8 bytes. In wide (32-bit) mode they sit 4 bytes apart and the memory returns the useful half on the 16-bit data port, so one descriptor spans 16 bytes.

When a packet leaves too little room, or does not fit, the block marks it as the last one for this buffer. It then fetches the next descriptor by itself, or it stops reception when the ring holds no fresh descriptor. The exhausted flag tells the host that the descriptor just loaded is the last one available.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, rd_ptr, buf_addr and buf_words are zero. exhausted, area_exceeded, last_pkt, rx_stop, cmd_pending, fetch_busy and mem_req are low. The low-space threshold holds 0x02F8.
- R2: A pulse on cfg_we writes cfg_wdata to the register selected by cfg_sel: 0 ring start, 1 ring end, 2 read pointer, 3 write pointer, 4 low-space threshold. Pointer values are stored with bits 1:0 cleared in wide mode and with bit 0 cleared in narrow mode. The threshold is stored unmasked.
- R3: A fetch makes four reads at rd_ptr, rd_ptr+s, rd_ptr+2s and rd_ptr+3s, with s = 2 in narrow mode and s = 4 in wide mode. Each read holds mem_req high with a stable mem_addr until mem_rvalid. The words go into buf_addr[15:0], buf_addr[31:16], buf_words[15:0] and buf_words[31:16], in that order.
- R4: When a fetch completes, rd_ptr advances by 4s. If the result equals the ring end, rd_ptr is reloaded with the ring start.
- R5: If the advanced rd_ptr equals the write pointer, exhausted is set and stays set. A pulse on exh_clr while exhausted is set clears it and starts a fetch. A pulse on exh_clr while exhausted is clear has no effect.
- R6: A pulse on fetch_cmd while no fetch is active sets cmd_pending and starts a fetch. cmd_pending clears when that fetch completes.
- R7: An accepted packet of pkt_len bytes needs P bytes, where P is pkt_len+4 rounded up to a multiple of 4 in wide mode or of 2 in narrow mode. When P is at most twice buf_words, buf_words drops by P/2 and buf_addr rises by P.
- R8: When P exceeds twice buf_words, buf_words and buf_addr stay unchanged, and area_exceeded and last_pkt are set. A pulse on bae_clr clears area_exceeded.
- R9: Each accepted packet that fits sets last_pkt exactly when the new buf_words is below the threshold, and clears it otherwise.
- R10: When a packet sets last_pkt, the block starts a fetch if the read and write pointers differ. If they are equal it sets rx_stop instead. While rx_stop is high, packets are ignored. A completed fetch clears rx_stop.
- R11: A pkt_valid pulse has no effect while a fetch is active, or in a cycle where fetch_cmd or an effective exh_clr starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 32-bit descriptor layout |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 16 | Write data |
| fetch_cmd | input | 1 | Host-requested descriptor fetch |
| exh_clr | input | 1 | Write-one-to-clear of exhausted |
| bae_clr | input | 1 | Write-one-to-clear of area_exceeded |
| pkt_valid | input | 1 | One-cycle packet arrival strobe |
| pkt_len | input | 16 | Packet payload length in bytes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining 16-bit words in buffer |
| rd_ptr | output | 16 | Ring read pointer |
| fetch_busy | output | 1 | Fetch in progress |
| cmd_pending | output | 1 | Host fetch command outstanding |
| exhausted | output | 1 | Last available descriptor loaded |
| area_exceeded | output | 1 | Packet did not fit the buffer |
| last_pkt | output | 1 | Last packet for the current buffer |
| rx_stop | output | 1 | Reception halted for lack of descriptors |

## Verification
The properties assume that the host writes pointers only while no fetch runs, that the ring end is reachable from every read pointer by descriptor-size steps, and that the memory answers every request eventually. The stimulus keeps these assumptions. It issues each operation only when fetch_busy is low, and it builds every ring from whole descriptor blocks placed below 512 bytes. The memory model answers each pending read on a coin toss at every cycle. Any pulse given while a fetch runs is a deliberate check of R11.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int WORD_W     = 16;
    localparam int LEN_W      = 16;
    localparam int DESC_WORDS = 4;
    localparam int PAD_W      = LEN_W + 2;

    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_END    = 3'd1,
        SEL_READ   = 3'd2,
        SEL_WRITE  = 3'd3,
        SEL_THRESH = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] cnt_hi;
        logic [WORD_W-1:0] cnt_lo;
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] addr_lo;
    } rxdesc_t;

    // byte distance between consecutive descriptor words
    function automatic logic [WORD_W-1:0] word_step(input logic wide);
        return wide ? WORD_W'(4) : WORD_W'(2);
    endfunction

    function automatic logic [WORD_W-1:0] align_ptr(input logic [WORD_W-1:0] v,
                                                    input logic wide);
        return wide ? (v & ~WORD_W'(3)) : (v & ~WORD_W'(1));
    endfunction

    // payload plus 4 CRC bytes, rounded up to the bus width
    function automatic logic [PAD_W-1:0] pad_bytes(input logic [LEN_W-1:0] len,
                                                   input logic wide);
        logic [PAD_W-1:0] rx;
        rx = PAD_W'(len) + PAD_W'(4);
        if (wide) return (rx + PAD_W'(3)) & ~PAD_W'(3);
        return (rx + PAD_W'(1)) & ~PAD_W'(1);
    endfunction
endpackage

// File: rtl/rxring_ptrs.sv
module rxring_ptrs
    import rxring_pkg::*;
#(
    parameter logic [WORD_W-1:0] THRESH_RST = 16'h02F8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              advance,
    output logic [WORD_W-1:0] rd_ptr,
    output logic [WORD_W-1:0] wr_ptr,
    output logic [WORD_W-1:0] thresh,
    output logic [WORD_W-1:0] rd_ptr_adv
);
    logic [WORD_W-1:0] start_ptr, end_ptr, stepped;

    assign stepped    = rd_ptr + (word_step(wide) << 2);
    assign rd_ptr_adv = (stepped == end_ptr) ? start_ptr : stepped;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_ptr <= '0;
            end_ptr   <= '0;
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            thresh    <= THRESH_RST;
        end else begin
            if (advance) rd_ptr <= rd_ptr_adv;
            if (cfg_we) begin
                case (cfg_sel_e'(cfg_sel))
                    SEL_START:  start_ptr <= align_ptr(cfg_wdata, wide);
                    SEL_END:    end_ptr   <= align_ptr(cfg_wdata, wide);
                    SEL_READ:   if (!advance) rd_ptr <= align_ptr(cfg_wdata, wide);
                    SEL_WRITE:  wr_ptr    <= align_ptr(cfg_wdata, wide);
                    SEL_THRESH: thresh    <= cfg_wdata;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxring_fetch.sv
module rxring_fetch
    import rxring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              start,
    input  logic [WORD_W-1:0] base,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              done,
    output logic              active,
    output rxdesc_t           desc
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    logic                                busy;
    logic [IDX_W-1:0]                    idx;
    logic [WORD_W-1:0]                   addr;
    logic [DESC_WORDS-1:0][WORD_W-1:0]   words;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
            addr <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy && !done) begin
                busy <= 1'b1;
                idx  <= '0;
                addr <= base;
            end else if (busy && mem_rvalid) begin
                addr <= addr + word_step(wide);
                idx  <= idx + 1'b1;
                if (idx == IDX_W'(DESC_WORDS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else begin
            for (int k = 0; k < DESC_WORDS; k++) begin
                if (busy && mem_rvalid && idx == IDX_W'(k)) words[k] <= mem_rdata;
            end
        end
    end

    assign desc     = rxdesc_t'(words);
    assign mem_req  = busy;
    assign mem_addr = addr;
    assign active   = busy | done;
endmodule

// File: rtl/rxring_budget.sv
module rxring_budget
    import rxring_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wide,
    input  logic                pkt_take,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic [WORD_W-1:0]   thresh,
    input  logic                load,
    input  rxdesc_t             desc,
    input  logic                bae_clr,
    output logic [2*WORD_W-1:0] buf_addr,
    output logic [2*WORD_W-1:0] buf_words,
    output logic                bae,
    output logic                last_pkt,
    output logic                last_now
);
    localparam int CW = 2 * WORD_W;

    logic [PAD_W-1:0] pad;
    logic             fits;
    logic [CW-1:0]    words_after;

    assign pad         = pad_bytes(pkt_len, wide);
    assign fits        = {buf_words, 1'b0} >= (CW + 1)'(pad);
    assign words_after = buf_words - CW'(pad >> 1);
    assign last_now    = !fits || (words_after < CW'(thresh));

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_addr  <= '0;
            buf_words <= '0;
            bae       <= 1'b0;
            last_pkt  <= 1'b0;
        end else begin
            if (bae_clr) bae <= 1'b0;
            if (load) begin
                buf_addr  <= {desc.addr_hi, desc.addr_lo};
                buf_words <= {desc.cnt_hi, desc.cnt_lo};
            end else if (pkt_take) begin
                last_pkt <= last_now;
                if (fits) begin
                    buf_words <= words_after;
                    buf_addr  <= buf_addr + CW'(pad);
                end else begin
                    bae <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rxring_pkg::*;
#(
    parameter logic [15:0] THRESH_RST = 16'h02F8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wide_mode,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    input  logic        fetch_cmd,
    input  logic        exh_clr,
    input  logic        bae_clr,
    input  logic        pkt_valid,
    input  logic [15:0] pkt_len,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [15:0] mem_rdata,
    output logic [31:0] buf_addr,
    output logic [31:0] buf_words,
    output logic [15:0] rd_ptr,
    output logic        fetch_busy,
    output logic        cmd_pending,
    output logic        exhausted,
    output logic        area_exceeded,
    output logic        last_pkt,
    output logic        rx_stop
);
    logic [WORD_W-1:0] wr_ptr, thresh, rd_ptr_adv;
    logic              done, last_now, host_trig, pkt_take, start_fetch;
    rxdesc_t           desc;

    assign host_trig   = fetch_cmd || (exh_clr && exhausted);
    assign pkt_take    = pkt_valid && !fetch_busy && !rx_stop && !host_trig;
    assign start_fetch = !fetch_busy &&
                         (host_trig || (pkt_take && last_now && rd_ptr != wr_ptr));

    rxring_ptrs #(.THRESH_RST(THRESH_RST)) u_ptrs (
        .clk(clk), .rst(rst), .wide(wide_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .advance(done), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .thresh(thresh), .rd_ptr_adv(rd_ptr_adv)
    );

    rxring_fetch u_fetch (
        .clk(clk), .rst(rst), .wide(wide_mode), .start(start_fetch),
        .base(rd_ptr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
        .active(fetch_busy), .desc(desc)
    );

    rxring_budget u_budget (
        .clk(clk), .rst(rst), .wide(wide_mode), .pkt_take(pkt_take),
        .pkt_len(pkt_len), .thresh(thresh), .load(done), .desc(desc),
        .bae_clr(bae_clr), .buf_addr(buf_addr), .buf_words(buf_words),
        .bae(area_exceeded), .last_pkt(last_pkt), .last_now(last_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_pending <= 1'b0;
            exhausted   <= 1'b0;
            rx_stop     <= 1'b0;
        end else begin
            if (fetch_cmd && !fetch_busy) cmd_pending <= 1'b1;
            if (done) cmd_pending <= 1'b0;
            if (exh_clr) exhausted <= 1'b0;
            if (done && rd_ptr_adv == wr_ptr) exhausted <= 1'b1;
            if (pkt_take && last_now && rd_ptr == wr_ptr) rx_stop <= 1'b1;
            if (done) rx_stop <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic [15:0] mem_addr,
    input logic        fetch_busy,
    input logic        cmd_pending,
    input logic        rx_stop,
    input logic [15:0] rd_ptr,
    input logic [15:0] wr_ptr,
    input logic [31:0] buf_words
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_req_in_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> fetch_busy);

    p_ptr_even_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr[0] == 1'b0) && (wr_ptr[0] == 1'b0));

    p_cmd_done_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_pending) |-> $fell(fetch_busy));

    p_stop_full_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_stop) |-> (rd_ptr == wr_ptr));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_stop) |-> $fell(fetch_busy));

    p_words_grow_r7: assert property (@(posedge clk) disable iff (rst)
        (buf_words > $past(buf_words)) |-> $fell(fetch_busy));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
    .mem_addr(mem_addr), .fetch_busy(fetch_busy), .cmd_pending(cmd_pending),
    .rx_stop(rx_stop), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .buf_words(buf_words)
);

// File: tb/rx_ring_mgr_tb.sv
module rx_ring_mgr_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, wide_mode = 1'b0, cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0, pkt_len = '0, mem_rdata = '0;
    logic        fetch_cmd = 1'b0, exh_clr = 1'b0, bae_clr = 1'b0, pkt_valid = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic        mem_req, fetch_busy, cmd_pending, exhausted, area_exceeded, last_pkt, rx_stop;
    logic [15:0] mem_addr, rd_ptr;
    logic [31:0] buf_addr, buf_words;

    rx_ring_mgr u_dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .fetch_cmd(fetch_cmd),
        .exh_clr(exh_clr), .bae_clr(bae_clr), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
        .buf_words(buf_words), .rd_ptr(rd_ptr), .fetch_busy(fetch_busy),
        .cmd_pending(cmd_pending), .exhausted(exhausted),
        .area_exceeded(area_exceeded), .last_pkt(last_pkt), .rx_stop(rx_stop)
    );

    logic [15:0] mem [0:255];
    int n_checks = 0, n_err = 0, cycles = 0;
    bit timeout = 1'b0;

    // reference state
    logic [15:0] m_start, m_end, m_rp, m_wp, m_thr;
    logic [31:0] m_addr, m_wc;
    bit m_exh, m_bae, m_last, m_stop;

    always @(posedge clk) cycles++;

    // memory responder: answers a pending read on a coin toss
    always @(negedge clk) begin
        if (mem_req && $urandom_range(0, 1) == 1) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[mem_addr[8:1]];
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "rd_ptr", {16'h0, rd_ptr}, {16'h0, m_rp});
        chk(req, "buf_addr", buf_addr, m_addr);
        chk(req, "buf_words", buf_words, m_wc);
        chk(req, "exhausted", {31'h0, exhausted}, {31'h0, m_exh});
        chk(req, "area_exceeded", {31'h0, area_exceeded}, {31'h0, m_bae});
        chk(req, "last_pkt", {31'h0, last_pkt}, {31'h0, m_last});
        chk(req, "rx_stop", {31'h0, rx_stop}, {31'h0, m_stop});
        chk(req, "cmd_pending", {31'h0, cmd_pending}, 32'h0);
        chk(req, "mem_req", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic wait_idle();
        while (fetch_busy && !timeout) begin
            @(negedge clk);
            if (cycles > 150000) timeout = 1'b1;
        end
    endtask

    function automatic logic [15:0] mask_ptr(input logic [15:0] v);
        return wide_mode ? (v & 16'hFFFC) : (v & 16'hFFFE);
    endfunction

    function automatic int pad_of(input int len);
        if (wide_mode) return ((len + 4 + 3) / 4) * 4;
        return ((len + 4 + 1) / 2) * 2;
    endfunction

    function automatic int widx(input logic [15:0] base, input int k);
        int s = wide_mode ? 4 : 2;
        return ((int'(base) + k * s) >> 1) & 255;
    endfunction

    task automatic model_fetch();
        logic [15:0] w [4];
        logic [15:0] nxt;
        for (int k = 0; k < 4; k++) w[k] = mem[widx(m_rp, k)];
        m_addr = {w[1], w[0]};
        m_wc   = {w[3], w[2]};
        nxt = m_rp + (wide_mode ? 16'd16 : 16'd8);
        if (nxt == m_end) nxt = m_start;
        m_rp = nxt;
        if (m_rp == m_wp) m_exh = 1'b1;
        m_stop = 1'b0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            if (!wide_mode)
                mem[i] = (i % 4 == 3) ? 16'h0 : (i % 4 == 2) ? 16'($urandom_range(0, 16'h500))
                                                             : 16'($urandom);
            else
                mem[i] = (i % 8 == 6) ? 16'h0 : (i % 8 == 4) ? 16'($urandom_range(0, 16'h500))
                                                             : 16'($urandom);
        end
    endtask

    task automatic put_desc(input logic [15:0] at, input logic [31:0] a, input logic [31:0] wc);
        mem[widx(at, 0)] = a[15:0];
        mem[widx(at, 1)] = a[31:16];
        mem[widx(at, 2)] = wc[15:0];
        mem[widx(at, 3)] = wc[31:16];
    endtask

    // all tasks start and end at a negative edge
    task automatic op_cfg(input logic [2:0] sel, input logic [15:0] d);
        case (sel)
            3'd0: m_start = mask_ptr(d);
            3'd1: m_end   = mask_ptr(d);
            3'd2: m_rp    = mask_ptr(d);
            3'd3: m_wp    = mask_ptr(d);
            3'd4: m_thr   = d;
            default: ;
        endcase
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic op_ring(input logic [15:0] s, input logic [15:0] e,
                           input logic [15:0] r, input logic [15:0] w);
        op_cfg(3'd0, s); op_cfg(3'd1, e); op_cfg(3'd2, r); op_cfg(3'd3, w);
    endtask

    task automatic op_cmd();
        fetch_cmd = 1'b1;
        @(negedge clk);
        fetch_cmd = 1'b0;
        chk("R6", "cmd_pending set", {31'h0, cmd_pending}, 32'h1);
        model_fetch();
        wait_idle();
        compare_all("R6");
    endtask

    task automatic op_exh_clr();
        bit had = m_exh;
        exh_clr = 1'b1;
        @(negedge clk);
        exh_clr = 1'b0;
        if (had) begin
            m_exh = 1'b0;
            chk("R5", "fetch started", {31'h0, fetch_busy}, 32'h1);
            model_fetch();
        end
        wait_idle();
        compare_all("R5");
    endtask

    task automatic op_bae_clr();
        bae_clr = 1'b1;
        @(negedge clk);
        bae_clr = 1'b0;
        m_bae = 1'b0;
        compare_all("R8");
    endtask

    task automatic model_pkt(input int len);
        int pad;
        longint wa;
        bit fits, ln;
        if (m_stop) return;
        pad  = pad_of(len);
        fits = longint'(pad) <= 2 * longint'(m_wc);
        if (fits) begin
            wa = longint'(m_wc) - pad / 2;
            ln = wa < longint'(m_thr);
            m_wc   = 32'(wa);
            m_addr = m_addr + 32'(pad);
        end else begin
            ln = 1'b1;
            m_bae = 1'b1;
        end
        m_last = ln;
        if (ln) begin
            if (m_rp == m_wp) m_stop = 1'b1;
            else model_fetch();
        end
    endtask

    task automatic op_pkt(input int len, input string req);
        pkt_valid = 1'b1; pkt_len = 16'(len);
        @(negedge clk);
        pkt_valid = 1'b0;
        model_pkt(len);
        wait_idle();
        compare_all(req);
    endtask

    task automatic rand_ring();
        int blk = wide_mode ? 16 : 8;
        int n = $urandom_range(2, 6);
        int s = blk * $urandom_range(0, 8);
        op_ring(16'(s), 16'(s + n * blk), 16'(s + blk * $urandom_range(0, n - 1)),
                16'(s + blk * $urandom_range(0, n - 1)));
    endtask

    initial begin
        process::self().srandom(32'd1234);
        m_start = '0; m_end = '0; m_rp = '0; m_wp = '0; m_thr = 16'h02F8;
        m_addr = '0; m_wc = '0; m_exh = 0; m_bae = 0; m_last = 0; m_stop = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");
        chk("R1", "fetch_busy", {31'h0, fetch_busy}, 32'h0);

        // R2 masking in both modes, observed on rd_ptr
        wide_mode = 1'b1;
        op_cfg(3'd2, 16'h1237);
        chk("R2", "wide mask", {16'h0, rd_ptr}, 32'h1234);
        wide_mode = 1'b0;
        op_cfg(3'd2, 16'h1237);
        chk("R2", "narrow mask", {16'h0, rd_ptr}, 32'h1236);

        // R9 with the reset threshold 0x02F8
        fill_mem();
        op_ring(16'h0000, 16'h0020, 16'h0000, 16'h0018);
        put_desc(16'h0000, 32'h0001_0000, 32'd762);
        op_cmd();
        op_pkt(0, "R9");
        chk("R9", "at threshold", {31'h0, last_pkt}, 32'h0);
        op_pkt(0, "R9");
        chk("R9", "below threshold, auto fetch R10", {16'h0, rd_ptr}, 32'h10);

        // R4 wrap and R5 exhaustion: rp 0x10 -> 0x18 hits wp -> wraps at 0x20
        op_cmd();
        chk("R5", "exhausted at wp", {31'h0, exhausted}, 32'h1);
        op_exh_clr();
        chk("R4", "wrap to start", {16'h0, rd_ptr}, 32'h0);
        op_exh_clr();   // exhausted is clear: no effect
        chk("R5", "no effect", {16'h0, rd_ptr}, 32'h0);

        // R11: packet while fetch active is ignored
        fetch_cmd = 1'b1;
        @(negedge clk);
        fetch_cmd = 1'b0;
        pkt_valid = 1'b1; pkt_len = 16'd40;
        @(negedge clk);
        pkt_valid = 1'b0;
        model_fetch();
        wait_idle();
        compare_all("R11");

        // R8 oversize, then R10 stop: rp 0x10, wp 0x10
        op_ring(16'h0000, 16'h0020, 16'h0008, 16'h0010);
        put_desc(16'h0008, 32'h0000_2000, 32'd4);
        op_cmd();
        op_pkt(100, "R8");
        chk("R8", "area exceeded", {31'h0, area_exceeded}, 32'h1);
        chk("R10", "stopped", {31'h0, rx_stop}, 32'h1);
        op_pkt(2, "R10");
        chk("R10", "ignored when stopped", buf_words, m_wc);
        op_bae_clr();
        op_cmd();
        chk("R10", "stop released", {31'h0, rx_stop}, 32'h0);

        // R3 wide layout with a known descriptor, R7 accounting
        wide_mode = 1'b1;
        fill_mem();
        op_ring(16'h0040, 16'h0080, 16'h0040, 16'h0070);
        put_desc(16'h0040, 32'hCAFE_0100, 32'd2000);
        op_cmd();
        chk("R3", "wide desc addr", buf_addr, 32'hCAFE_0100);
        op_pkt(61, "R7");
        chk("R7", "wide pad 68", buf_words, 32'd1966);

        // constrained random mix
        for (int it = 0; it < 2500 && !timeout; it++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                wide_mode = $urandom_range(0, 1);
                fill_mem();
                rand_ring();
                op_cmd();
            end else if (r < 6) rand_ring();
            else if (r < 9) op_cfg(3'd4, 16'($urandom_range(0, 16'h400)));
            else if (r < 16) op_cmd();
            else if (r < 22) op_exh_clr();
            else if (r < 25) op_bae_clr();
            else op_pkt($urandom_range(0, 700), "R7");
        end

        if (timeout) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule